// File: doc/BRIEF.md
# SAR Conversion Sequencer with Self-Test

This block steps a successive-approximation converter through one conversion. It runs entirely on the free-running conversion clock. The serial side hands it a start request as a toggle on `start_tgl`, which may change at any time relative to that clock. The block passes the toggle through a synchronizer, detects the change, and then runs a conversion of fixed length. During each bit step it drives a trial code to an external DAC and comparator, and it reads back one greater-or-equal decision per bit, most significant bit first. At the end it stores the code in a result register and raises the end-of-conversion flag.

Three channel addresses select self-test levels instead of the external comparator. With these addresses the sequencer compares each trial code against a fixed internal level: the midpoint, the low reference or the high reference. A healthy control path therefore always returns the known codes for these channels. The serial side can abort a running conversion with `abort_req`. The block accepts the abort only once it has been seen in two consecutive synchronized samples, and the previous result stays in place.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset `eoc` is 1, `done` is 0, and both `result` and `trial_code` are 0.
- R2: A change of level on `start_tgl` that settles before a rising clock edge leaves `eoc` high after the second edge and pulls it low on the third edge. `chan_addr` is captured on that same third edge.
- R3: `done` and `eoc` both rise exactly 44 clock cycles after `eoc` falls. `done` is high for one cycle only.
- R4: For channel addresses 0x0 to 0xA, 0xE and 0xF, the stored result equals the largest code that the comparator reported as at or below the input. With a comparator that returns `vin >= trial_code`, the result is `vin`.
- R5: Bits are decided from the MSB down, 4 cycles per bit. The first trial (only bit 9 set) appears 2 cycles after `eoc` falls. Each later trial appears 4 cycles after the one before it, with the earlier bits decided and the next lower bit set.
- R6: `result` changes only at the end of a completed conversion. While `eoc` is high it holds its value.
- R7: Channel address 0xB yields 0x200 whatever the value of `cmp_ge`.
- R8: Channel address 0xC yields 0x000 whatever the value of `cmp_ge`.
- R9: Channel address 0xD yields 0x3FF whatever the value of `cmp_ge`.
- R10: If `abort_req` is held high during a conversion, `eoc` returns high within 6 cycles, no `done` pulse follows, and `result` keeps its previous value. The next start request converts normally.
- R11: A start toggle that arrives during a conversion is dropped. The running conversion keeps its length and result, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adclk | input | 1 | Free-running conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_tgl | input | 1 | Start request from the serial side; each change of level requests one conversion |
| chan_addr | input | 4 | Channel address; 0xB, 0xC and 0xD select the self-test levels |
| cmp_ge | input | 1 | Comparator decision: input at or above the trial code |
| abort_req | input | 1 | Chip-select abort request from the serial side, asynchronous |
| trial_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| eoc | output | 1 | End of conversion; low while a conversion runs |
| done | output | 1 | One-cycle pulse when a result is stored |

## Verification
The bench uses the default parameters: 10 bits, 4 cycles per bit step, 2 cycles of lead-in, 2 cycles of wind-down and 2 synchronizer stages. At that size all 1024 input codes can be converted in well under the cycle budget, rotating over the ordinary channels. It traces every intermediate trial code of every conversion against a value it works out itself. Because the synchronizer depth and the step length stay small, the exact edge on which the start is taken and the 44-cycle window can be checked cycle by cycle, together with aborts and start requests that arrive mid-conversion.

// File: rtl/sar_pkg.sv
// Package: shared constants and types for the SAR conversion sequencer.
// Assumes a 4-bit channel address with three fixed self-test codes.
package sar_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] CH_TEST_MID = 4'hB;
    localparam logic [ADDR_W-1:0] CH_TEST_LO  = 4'hC;
    localparam logic [ADDR_W-1:0] CH_TEST_HI  = 4'hD;

    // Where the bit decision comes from during a conversion.
    typedef enum logic [1:0] {
        REF_EXT = 2'd0,
        REF_MID = 2'd1,
        REF_LO  = 2'd2,
        REF_HI  = 2'd3
    } ref_sel_e;

    // Maps a channel address to its decision source.
    function automatic ref_sel_e ref_of_addr(input logic [ADDR_W-1:0] a);
        case (a)
            CH_TEST_MID: return REF_MID;
            CH_TEST_LO:  return REF_LO;
            CH_TEST_HI:  return REF_HI;
            default:     return REF_EXT;
        endcase
    endfunction

endpackage

// File: rtl/sar_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level (a toggle or a held request), not a short pulse.
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shreg;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], d};
        end
    end

    assign q = shreg[STAGES-1];

endmodule

// File: rtl/sar_step_ctrl.sv
// Module: timing controller for one fixed-length SAR conversion.
// Produces the per-bit set and decide masks and the store and finish strobes.
// Assumes PRE_CYC >= 1, STEP_CYC >= 2 and POST_CYC >= 2; start is taken only while idle.
module sar_step_ctrl #(
    parameter int NBITS    = 10,
    parameter int STEP_CYC = 4,
    parameter int PRE_CYC  = 2,
    parameter int POST_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    output logic             busy,
    output logic [NBITS-1:0] set_mask,
    output logic [NBITS-1:0] dec_mask,
    output logic             store_stb,
    output logic             fin_stb
);

    localparam int TOTAL  = PRE_CYC + STEP_CYC * NBITS + POST_CYC;
    localparam int CW     = $clog2(TOTAL);
    localparam int SW     = $clog2(STEP_CYC);
    localparam int BIT_LO = PRE_CYC;
    localparam int BIT_HI = PRE_CYC + STEP_CYC * NBITS;

    logic [CW-1:0]    cnt;
    logic [SW-1:0]    sub;
    logic [NBITS-1:0] mask;
    logic             in_bits;
    logic             first_set;
    logic             dec_now;

    // Decode the position within the conversion.
    always_comb begin
        in_bits   = busy && (cnt >= CW'(BIT_LO)) && (cnt < CW'(BIT_HI));
        first_set = busy && (cnt == CW'(PRE_CYC - 1));
        dec_now   = in_bits && (sub == SW'(STEP_CYC - 1));
        set_mask  = first_set ? mask : (dec_now ? (mask >> 1) : '0);
        dec_mask  = dec_now ? mask : '0;
        store_stb = busy && !abort && (cnt == CW'(TOTAL - 2));
        fin_stb   = busy && !abort && (cnt == CW'(TOTAL - 1));
    end

    // Busy flag: set by start, cleared by finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (fin_stb) begin
            busy <= 1'b0;
        end
    end

    // Whole-conversion cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Cycle counter within the current bit step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub <= '0;
        end else if (start) begin
            sub <= '0;
        end else if (in_bits) begin
            sub <= (sub == SW'(STEP_CYC - 1)) ? '0 : sub + SW'(1);
        end
    end

    // One-hot pointer to the bit under decision, walking MSB to LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (start) begin
            mask <= {1'b1, {(NBITS-1){1'b0}}};
        end else if (dec_now) begin
            mask <= mask >> 1;
        end
    end

endmodule

// File: rtl/sar_trial_path.sv
// Module: trial-code register, decision source select and result register.
// Assumes set_mask and dec_mask come from sar_step_ctrl, at most one bit each.
module sar_trial_path
    import sar_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [NBITS-1:0] set_mask,
    input  logic [NBITS-1:0] dec_mask,
    input  logic             cmp_ge,
    input  ref_sel_e         ref_sel,
    input  logic             store,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] result
);

    logic [NBITS-1:0] level;
    logic             ge_eff;

    // Choose the decision: the external comparator, or a compare against a fixed self-test level.
    always_comb begin
        level = '0;
        case (ref_sel)
            REF_MID: level[NBITS-1] = 1'b1;
            REF_HI:  level = '1;
            default: level = '0;
        endcase
        ge_eff = (ref_sel == REF_EXT) ? cmp_ge : (level >= trial);
    end

    // Trial register: drop a rejected bit, then set the next trial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (clear) begin
            trial <= '0;
        end else begin
            trial <= (trial & ~(dec_mask & {NBITS{~ge_eff}})) | set_mask;
        end
    end

    // Result register: written only on a completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (store) begin
            result <= trial;
        end
    end

endmodule

// File: rtl/sar_conv_seq.sv
// Module: top of the SAR conversion sequencer.
// Synchronizes the start toggle and the abort request, runs a fixed-length
// conversion and drives eoc and done. Assumes start_tgl is a level that changes
// once per request, and that abort_req is held for several clock cycles.
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int NBITS       = 10,
    parameter int STEP_CYC    = 4,
    parameter int PRE_CYC     = 2,
    parameter int POST_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              adclk,
    input  logic              rst_n,
    input  logic              start_tgl,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic              cmp_ge,
    input  logic              abort_req,
    output logic [NBITS-1:0]  trial_code,
    output logic [NBITS-1:0]  result,
    output logic              eoc,
    output logic              done
);

    logic              start_s, start_q, start_p;
    logic              abort_s, abort_q, abort_v, abort_hit;
    logic              start_ok;
    logic              busy;
    logic [NBITS-1:0]  set_mask, dec_mask;
    logic              store_stb, fin_stb;
    logic [ADDR_W-1:0] addr_q;
    ref_sel_e          ref_sel;

    sar_sync #(.STAGES(SYNC_STAGES)) i_start_sync (
        .clk   (adclk),
        .rst_n (rst_n),
        .d     (start_tgl),
        .q     (start_s)
    );

    sar_sync #(.STAGES(SYNC_STAGES)) i_abort_sync (
        .clk   (adclk),
        .rst_n (rst_n),
        .d     (abort_req),
        .q     (abort_s)
    );

    // Keep one more sample of each synchronized input, for edge detection and filtering.
    always_ff @(posedge adclk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= start_s;
            abort_q <= abort_s;
        end
    end

    // Turn the toggle into a start pulse, and require two equal abort samples.
    always_comb begin
        start_p   = start_s ^ start_q;
        abort_v   = abort_s & abort_q;
        abort_hit = abort_v & busy;
        start_ok  = start_p & ~busy & ~abort_v;
        ref_sel   = ref_of_addr(addr_q);
    end

    // Capture the channel address when a conversion starts.
    always_ff @(posedge adclk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (start_ok) begin
            addr_q <= chan_addr;
        end
    end

    sar_step_ctrl #(
        .NBITS    (NBITS),
        .STEP_CYC (STEP_CYC),
        .PRE_CYC  (PRE_CYC),
        .POST_CYC (POST_CYC)
    ) i_ctrl (
        .clk       (adclk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .abort     (abort_hit),
        .busy      (busy),
        .set_mask  (set_mask),
        .dec_mask  (dec_mask),
        .store_stb (store_stb),
        .fin_stb   (fin_stb)
    );

    sar_trial_path #(.NBITS(NBITS)) i_path (
        .clk      (adclk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .set_mask (set_mask),
        .dec_mask (dec_mask),
        .cmp_ge   (cmp_ge),
        .ref_sel  (ref_sel),
        .store    (store_stb),
        .trial    (trial_code),
        .result   (result)
    );

    // End-of-conversion flag and the one-cycle done pulse.
    always_ff @(posedge adclk) begin
        if (!rst_n) begin
            eoc  <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= fin_stb;
            if (start_ok) begin
                eoc <= 1'b0;
            end else if (fin_stb || abort_hit) begin
                eoc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_conv_seq_chk.sv
// Module: property checker for sar_conv_seq, bound to every instance of it.
// Assumes the address seen is the one captured at the start of the conversion.
module sar_conv_seq_chk #(
    parameter int NBITS = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eoc,
    input logic             done,
    input logic [NBITS-1:0] result,
    input logic [NBITS-1:0] trial_code,
    input logic [3:0]       test_addr
);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> eoc);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> $stable(result));

    // R4
    result_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == trial_code));

    // R7
    mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_addr == 4'hB) |-> (result == {1'b1, {(NBITS-1){1'b0}}}));

    // R8
    lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_addr == 4'hC) |-> (result == '0));

    // R9
    hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_addr == 4'hD) |-> (result == '1));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS)) i_chk (
    .clk        (adclk),
    .rst_n      (rst_n),
    .eoc        (eoc),
    .done       (done),
    .result     (result),
    .trial_code (trial_code),
    .test_addr  (addr_q)
);

// File: tb/test_sar_conv_seq.sv
// Bench: sweeps all input codes through the sequencer and checks timing,
// trial progression, self-test codes, aborts and dropped starts.
module test_sar_conv_seq;

    localparam int CLK_P = 10;
    localparam int NB    = 10;
    localparam int TOTAL = 44;

    logic          adclk     = 1'b0;
    logic          rst_n     = 1'b0;
    logic          start_tgl = 1'b0;
    logic          abort_req = 1'b0;
    logic [3:0]    chan_addr = 4'h0;
    logic          cmp_ge;
    logic [NB-1:0] trial_code;
    logic [NB-1:0] result;
    logic          eoc;
    logic          done;

    logic [NB-1:0] vin       = '0;
    logic          force_en  = 1'b0;
    logic          force_val = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) adclk = ~adclk;

    // Comparator model: input at or above the trial code, unless forced.
    assign cmp_ge = force_en ? force_val : (vin >= trial_code);

    sar_conv_seq i_sar_conv_seq (
        .adclk      (adclk),
        .rst_n      (rst_n),
        .start_tgl  (start_tgl),
        .chan_addr  (chan_addr),
        .cmp_ge     (cmp_ge),
        .abort_req  (abort_req),
        .trial_code (trial_code),
        .result     (result),
        .eoc        (eoc),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One full conversion, from the start toggle to the done pulse.
    task automatic run_conv(input int v, input int a, input int expv, input string req, input bit trace);
        vin       = NB'(v);
        chan_addr = 4'(a);
        start_tgl = ~start_tgl;
        repeat (2) @(negedge adclk);
        chk(eoc == 1'b1, "R2", int'(eoc), 1);
        @(negedge adclk);
        chk(eoc == 1'b0, "R2", int'(eoc), 0);
        for (int m = 1; m <= TOTAL; m++) begin
            @(negedge adclk);
            if (trace && m >= 2 && m <= 2 + 4 * (NB - 1) && ((m - 2) % 4) == 0) begin
                int k;
                int topm;
                int e;
                k    = (m - 2) / 4;
                topm = ((1 << k) - 1) << (NB - k);
                e    = (v & topm) | (1 << (NB - 1 - k));
                chk(int'(trial_code) == e, "R5", int'(trial_code), e);
            end
            if (m == TOTAL - 1) begin
                chk(done == 1'b0 && eoc == 1'b0, "R3", int'({done, eoc}), 0);
            end
        end
        chk(done == 1'b1 && eoc == 1'b1, "R3", int'({done, eoc}), 3);
        chk(int'(result) == expv, req, int'(result), expv);
        @(negedge adclk);
        chk(done == 1'b0, "R3", int'(done), 0);
    endtask

    initial begin
        repeat (4) @(negedge adclk);
        rst_n = 1'b1;
        @(negedge adclk);
        // R1 reset state
        chk(eoc == 1'b1, "R1", int'(eoc), 1);
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(result == '0, "R1", int'(result), 0);
        chk(trial_code == '0, "R1", int'(trial_code), 0);

        // R4 R5: every code, rotating over the ordinary channels 0x0..0xA
        for (int v = 0; v < (1 << NB); v++) begin
            run_conv(v, v % 11, v, "R4", 1'b1);
        end
        run_conv(777, 14, 777, "R4", 1'b1);
        run_conv(42, 15, 42, "R4", 1'b1);

        // R7 R8 R9: self-test channels ignore the comparator
        force_en = 1'b1;
        for (int f = 0; f < 2; f++) begin
            force_val = f[0];
            run_conv(0, 11, 'h200, "R7", 1'b0);
            run_conv(0, 12, 'h000, "R8", 1'b0);
            run_conv(0, 13, 'h3FF, "R9", 1'b0);
        end
        force_en = 1'b0;

        // R6: result holds while idle although the input moves
        run_conv(321, 2, 321, "R4", 1'b1);
        vin = 10'd5;
        repeat (20) @(negedge adclk);
        chk(int'(result) == 321, "R6", int'(result), 321);

        // R10: abort mid-conversion
        begin
            int seen_done;
            vin       = 10'd900;
            chan_addr = 4'h3;
            start_tgl = ~start_tgl;
            repeat (3) @(negedge adclk);
            chk(eoc == 1'b0, "R10", int'(eoc), 0);
            repeat (10) @(negedge adclk);
            abort_req = 1'b1;
            repeat (6) @(negedge adclk);
            chk(eoc == 1'b1, "R10", int'(eoc), 1);
            seen_done = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge adclk);
                if (done) seen_done++;
            end
            chk(seen_done == 0, "R10", seen_done, 0);
            chk(int'(result) == 321, "R10", int'(result), 321);
            abort_req = 1'b0;
            repeat (6) @(negedge adclk);
            run_conv(600, 4, 600, "R10", 1'b1);
        end

        // R11: a second start inside a conversion is dropped
        begin
            int seen_done;
            vin       = 10'd123;
            chan_addr = 4'h1;
            start_tgl = ~start_tgl;
            repeat (3) @(negedge adclk);
            chk(eoc == 1'b0, "R11", int'(eoc), 0);
            repeat (10) @(negedge adclk);
            start_tgl = ~start_tgl;
            repeat (TOTAL - 11) @(negedge adclk);
            chk(done == 1'b0, "R11", int'(done), 0);
            @(negedge adclk);
            chk(done == 1'b1 && int'(result) == 123, "R11", int'(result), 123);
            seen_done = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge adclk);
                if (done || !eoc) seen_done++;
            end
            chk(seen_done == 0, "R11", seen_done, 0);
        end

        finished = 1;
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge adclk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R3: actual hang expected completion");
            report();
            $finish;
        end
    end

endmodule